// File: doc/BRIEF.md
# Pin Trigger and Acknowledge Engine

This block holds the per-pin request logic of an interrupt routing controller. Each pin's raw level is optionally inverted, then registered into a request latch. Edge-mode pins post a single service request when that latch changes from 0 to 1. Level-mode pins ask for service for as long as the latch is set and the pin's in-service flag is clear. A fixed-priority picker chooses the lowest-numbered pin that needs service. A two-state machine then presents one delivery message and holds it until the receiver answers with accept or reject.

The message carries the vector, destination, destination mode, delivery mode and trigger mode from the granted pin's configuration. It always carries an asserted level and a zero shorthand field. Pin 0 is always sent in physical mode to destination 0. The end-of-interrupt input carries a vector. Every pin whose configured vector equals it gets a one-cycle acknowledge pulse. A level pin that matches also has its in-service flag cleared, and it is offered again if its request is still set and it is unmasked.

The state machine has two states. `ST_IDLE` offers no message. The transition `grant` moves it to `ST_WAIT` when any pin needs service, and the chosen pin's fields are captured in that step. `ST_WAIT` drives `msg_valid` high and holds the fields. The transition `respond` returns it to `ST_IDLE` on `msg_done`, and the pin's flags are updated from `msg_accepted` at that point.

Top module: `pin_trigger_engine`

## Requirements
- R1: The effective level of a pin is `pin_raw XOR cfg_polarity`. The request latch takes the effective level every cycle, so an effective low clears it.
- R2: An edge-mode pin (`cfg_level_mode`=0) produces one message per 0-to-1 change of its latch. An input that stays high produces nothing more until it goes low and high again.
- R3: A level-mode pin (`cfg_level_mode`=1) is offered whenever its latch is set, it is unmasked and its in-service flag is clear. A rejected level delivery is therefore offered again.
- R4: A masked pin (`cfg_mask`=1) is never offered. An edge that arrives while the pin is masked is lost, even if the pin is unmasked later while its input is still high.
- R5: When a level-mode delivery is accepted, the pin's in-service flag is set. The pin is then not offered again while its input stays high.
- R6: An end-of-interrupt clears the in-service flag of every level-mode pin whose vector matches `eoi_vector`. Each such pin that is still requesting and unmasked is offered again.
- R7: One cycle after `eoi_valid`, `ack_pin` has a bit set for every pin whose vector matches `eoi_vector`, for one cycle only. Bit i of `ack_pin` is pin i.
- R8: A message from pin 0 has `msg_dest`=0 and `msg_dest_logical`=0, whatever the pin 0 configuration holds. Other pins pass their configured values through.
- R9: Every message has `msg_assert`=1 and `msg_shorthand`=0. `msg_level_trig` equals the pin's `cfg_level_mode`, and `msg_dlv_mode` equals the pin's 3-bit delivery mode field.
- R10: When several pins need service at the same time, they are granted in ascending pin order, one message at a time.
- R11: After reset no message is offered and `ack_pin` is 0. An offered message keeps all of its fields stable until `msg_done`. A rejected edge delivery is dropped and not retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NUM_PINS | Raw input pin levels |
| cfg_polarity | input | NUM_PINS | Per-pin inversion bit |
| cfg_level_mode | input | NUM_PINS | 1 = level mode, 0 = edge mode |
| cfg_mask | input | NUM_PINS | 1 = pin masked |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector; pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination; pin i at bits [i*DEST_W +: DEST_W] |
| cfg_dest_logical | input | NUM_PINS | Per-pin destination mode, 1 = logical |
| cfg_dlv_mode | input | NUM_PINS*3 | Per-pin delivery mode; pin i at bits [i*3 +: 3] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector that the end-of-interrupt carries |
| msg_done | input | 1 | Receiver response strobe for the held message |
| msg_accepted | input | 1 | With msg_done: 1 = accepted, 0 = rejected |
| msg_valid | output | 1 | A delivery message is being offered |
| msg_pin | output | PIN_W | Pin that the message comes from |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_logical | output | 1 | Message destination mode |
| msg_dlv_mode | output | 3 | Message delivery mode |
| msg_level_trig | output | 1 | Message trigger mode, 1 = level |
| msg_assert | output | 1 | Message level, always 1 |
| msg_shorthand | output | 2 | Destination shorthand, always 0 |
| ack_pin | output | NUM_PINS | Per-pin acknowledge pulse after an end-of-interrupt |

## Verification
The bench holds an edge pin high for many cycles after one delivery. A design that compares against a latch cleared by servicing would produce a stream of repeated messages here. Level pins that share a vector are used to check that an end-of-interrupt acknowledges and re-offers every matching pin, in ascending order, and that a pin whose input has dropped is not re-offered. A design that releases only the first matching pin, or that ignores the request latch on release, shows up in these checks. The bench also covers several other cases:
- an edge that arrives while the pin is masked;
- a rejected edge delivery and a rejected level delivery;
- pin 0 given a logical destination in its configuration;
- a configuration change while a message is held.

A design that fires on unmask, retries edges, lets level pins go silent, skips the pin 0 override or lets the held message change would each fail a named check.

// File: rtl/pte_pkg.sv
package pte_pkg;
    localparam int DLV_W = 3;
    localparam int SH_W  = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pte_state_e;
endpackage

// File: rtl/pte_pin_slice.sv
module pte_pin_slice #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             polarity,
    input  logic             level_mode,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             done_hit,
    input  logic             done_accept,
    output logic             want,
    output logic             ack
);
    logic eff, req_q, pend_q, remote_q, eoi_hit, rise;

    assign eff     = pin_raw ^ polarity;
    assign rise    = eff & ~req_q;
    assign eoi_hit = eoi_valid && (vector == eoi_vector);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            pend_q   <= 1'b0;
            remote_q <= 1'b0;
            ack      <= 1'b0;
        end else begin
            req_q <= eff;
            ack   <= eoi_hit;
            if (!level_mode && rise && !mask)
                pend_q <= 1'b1;
            else if (done_hit || mask || level_mode)
                pend_q <= 1'b0;
            if (!level_mode)
                remote_q <= 1'b0;
            else if (done_hit && done_accept)
                remote_q <= 1'b1;
            else if (eoi_hit)
                remote_q <= 1'b0;
        end
    end

    assign want = level_mode ? (req_q & ~remote_q & ~mask) : pend_q;

    // R2
    edge_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && $rose(pend_q)) |-> $rose(req_q));
    // R5
    remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote_q) |-> $past(done_hit && done_accept));
    // R6
    remote_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(remote_q) |-> $past(eoi_hit || !level_mode));
endmodule

// File: rtl/pte_prio_pick.sv
module pte_prio_pick #(
    parameter int NUM_PINS = 8,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] want,
    output logic                any,
    output logic [PIN_W-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (want[i]) idx = PIN_W'(i);
        end
    end
    assign any = |want;

    // R10
    pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> want[idx]);
endmodule

// File: rtl/pin_trigger_engine.sv
module pin_trigger_engine #(
    parameter int NUM_PINS = 8,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PINS-1:0]          pin_raw,
    input  logic [NUM_PINS-1:0]          cfg_polarity,
    input  logic [NUM_PINS-1:0]          cfg_level_mode,
    input  logic [NUM_PINS-1:0]          cfg_mask,
    input  logic [NUM_PINS*VEC_W-1:0]    cfg_vector,
    input  logic [NUM_PINS*DEST_W-1:0]   cfg_dest,
    input  logic [NUM_PINS-1:0]          cfg_dest_logical,
    input  logic [NUM_PINS*3-1:0]        cfg_dlv_mode,
    input  logic                         eoi_valid,
    input  logic [VEC_W-1:0]             eoi_vector,
    input  logic                         msg_done,
    input  logic                         msg_accepted,
    output logic                         msg_valid,
    output logic [PIN_W-1:0]             msg_pin,
    output logic [VEC_W-1:0]             msg_vector,
    output logic [DEST_W-1:0]            msg_dest,
    output logic                         msg_dest_logical,
    output logic [2:0]                   msg_dlv_mode,
    output logic                         msg_level_trig,
    output logic                         msg_assert,
    output logic [1:0]                   msg_shorthand,
    output logic [NUM_PINS-1:0]          ack_pin
);
    import pte_pkg::*;

    pte_state_e          state, state_nx;
    logic [NUM_PINS-1:0] want;
    logic                any_want;
    logic [PIN_W-1:0]    pick;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pte_pin_slice #(.VEC_W(VEC_W)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_raw     (pin_raw[i]),
            .polarity    (cfg_polarity[i]),
            .level_mode  (cfg_level_mode[i]),
            .mask        (cfg_mask[i]),
            .vector      (cfg_vector[i*VEC_W +: VEC_W]),
            .eoi_valid   (eoi_valid),
            .eoi_vector  (eoi_vector),
            .done_hit    (state == ST_WAIT && msg_done && msg_pin == PIN_W'(i)),
            .done_accept (msg_accepted),
            .want        (want[i]),
            .ack         (ack_pin[i])
        );
    end

    pte_prio_pick #(.NUM_PINS(NUM_PINS)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .any   (any_want),
        .idx   (pick)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any_want) state_nx = ST_WAIT;
            ST_WAIT: if (msg_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_pin          <= '0;
            msg_vector       <= '0;
            msg_dest         <= '0;
            msg_dest_logical <= 1'b0;
            msg_dlv_mode     <= '0;
            msg_level_trig   <= 1'b0;
        end else if (state == ST_IDLE && any_want) begin
            msg_pin        <= pick;
            msg_vector     <= cfg_vector[pick*VEC_W +: VEC_W];
            msg_dlv_mode   <= cfg_dlv_mode[pick*3 +: 3];
            msg_level_trig <= cfg_level_mode[pick];
            if (pick == '0) begin
                msg_dest         <= '0;
                msg_dest_logical <= 1'b0;
            end else begin
                msg_dest         <= cfg_dest[pick*DEST_W +: DEST_W];
                msg_dest_logical <= cfg_dest_logical[pick];
            end
        end
    end

    assign msg_valid     = (state == ST_WAIT);
    assign msg_assert    = 1'b1;
    assign msg_shorthand = '0;

    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_done) |=> (msg_valid && $stable(msg_pin)
            && $stable(msg_vector) && $stable(msg_dest)));
    // R8
    pin0_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_pin == '0) |-> (msg_dest == '0 && !msg_dest_logical));
endmodule

// File: tb/pin_trigger_engine_test.sv
module pin_trigger_engine_test;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int DW = 8;
    localparam int PW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0]    pin_raw, cfg_polarity, cfg_level_mode, cfg_mask, cfg_dest_logical;
    logic [N*VW-1:0] cfg_vector;
    logic [N*DW-1:0] cfg_dest;
    logic [N*3-1:0]  cfg_dlv_mode;
    logic            eoi_valid, msg_done, msg_accepted;
    logic [VW-1:0]   eoi_vector;
    logic            msg_valid, msg_dest_logical, msg_level_trig, msg_assert;
    logic [PW-1:0]   msg_pin;
    logic [VW-1:0]   msg_vector;
    logic [DW-1:0]   msg_dest;
    logic [2:0]      msg_dlv_mode;
    logic [1:0]      msg_shorthand;
    logic [N-1:0]    ack_pin;

    int n_tests = 0;
    int n_fail  = 0;

    logic [PW-1:0] cap_pin;
    logic [VW-1:0] cap_vec;
    logic [DW-1:0] cap_dest;
    logic          cap_log, cap_lt, cap_as;
    logic [2:0]    cap_dlv;
    logic [1:0]    cap_sh;

    always #10 clk = ~clk;

    pin_trigger_engine #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_polarity(cfg_polarity),
        .cfg_level_mode(cfg_level_mode), .cfg_mask(cfg_mask), .cfg_vector(cfg_vector),
        .cfg_dest(cfg_dest), .cfg_dest_logical(cfg_dest_logical), .cfg_dlv_mode(cfg_dlv_mode),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_done(msg_done),
        .msg_accepted(msg_accepted), .msg_valid(msg_valid), .msg_pin(msg_pin),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
        .msg_dlv_mode(msg_dlv_mode), .msg_level_trig(msg_level_trig), .msg_assert(msg_assert),
        .msg_shorthand(msg_shorthand), .ack_pin(ack_pin)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        pin_raw = '0; cfg_polarity = '0; cfg_level_mode = '0; cfg_mask = '1;
        cfg_dest_logical = '0; cfg_vector = '0; cfg_dest = '0; cfg_dlv_mode = '0;
        eoi_valid = 1'b0; eoi_vector = '0; msg_done = 1'b0; msg_accepted = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic serve(input bit acc, output bit got);
        got = 1'b0;
        for (int k = 0; k < 12 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) got = 1'b1;
        end
        if (got) begin
            cap_pin = msg_pin; cap_vec = msg_vector; cap_dest = msg_dest;
            cap_log = msg_dest_logical; cap_lt = msg_level_trig; cap_as = msg_assert;
            cap_dlv = msg_dlv_mode; cap_sh = msg_shorthand;
            msg_done = 1'b1; msg_accepted = acc;
            @(negedge clk);
            msg_done = 1'b0; msg_accepted = 1'b0;
        end
    endtask

    task automatic quiet(input int n, input string req, input string what);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        chk(!seen, req, what, seen, 0);
    endtask

    task automatic eoi(input logic [VW-1:0] v, input logic [N-1:0] exp_ack, input string req);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
        chk(ack_pin == exp_ack, req, "ack pulse", ack_pin, exp_ack);
        @(negedge clk);
        chk(ack_pin == '0, req, "ack one cycle", ack_pin, 0);
    endtask

    task automatic t_reset();
        reset_dut();
        chk(!msg_valid, "R11", "no message after reset", msg_valid, 0);
        chk(ack_pin == '0, "R11", "ack after reset", ack_pin, 0);
    endtask

    task automatic t_edge();
        bit got;
        reset_dut();
        cfg_vector[3*VW +: VW] = 8'h33; cfg_mask[3] = 1'b0;
        pin_raw[3] = 1'b1;
        serve(1'b1, got);
        chk(got && cap_pin == 3 && cap_vec == 8'h33 && !cap_lt, "R2", "edge message",
            {got, cap_vec}, {1'b1, 8'h33});
        quiet(10, "R2", "held high gives no repeat");
        pin_raw[3] = 1'b0;
        @(negedge clk);
        pin_raw[3] = 1'b1;
        serve(1'b1, got);
        chk(got && cap_pin == 3, "R2", "second edge", got, 1);
    endtask

    task automatic t_polarity();
        bit got;
        reset_dut();
        pin_raw[4] = 1'b1; cfg_polarity[4] = 1'b1; cfg_mask[4] = 1'b0;
        quiet(4, "R1", "inverted high is effective low");
        pin_raw[4] = 1'b0;
        serve(1'b1, got);
        chk(got && cap_pin == 4, "R1", "inverted low fires", {got, 3'(cap_pin)}, {1'b1, 3'd4});
        pin_raw[4] = 1'b1;
        quiet(6, "R1", "inverted high clears latch");
        pin_raw[4] = 1'b0;
        serve(1'b1, got);
        chk(got, "R1", "latch cleared so new edge fires", got, 1);
    endtask

    task automatic t_mask();
        bit got;
        reset_dut();
        pin_raw[5] = 1'b1;
        quiet(5, "R4", "masked edge");
        cfg_mask[5] = 1'b0;
        quiet(5, "R4", "unmask while high is no edge");
        pin_raw[5] = 1'b0;
        @(negedge clk);
        pin_raw[5] = 1'b1;
        serve(1'b1, got);
        chk(got && cap_pin == 5, "R4", "unmasked edge fires", got, 1);
    endtask

    task automatic t_level_eoi();
        bit got;
        reset_dut();
        cfg_vector[2*VW +: VW] = 8'h52; cfg_vector[6*VW +: VW] = 8'h52;
        cfg_level_mode[2] = 1'b1; cfg_level_mode[6] = 1'b1;
        cfg_mask[2] = 1'b0; cfg_mask[6] = 1'b0;
        cfg_dlv_mode[6*3 +: 3] = 3'b101;
        pin_raw[2] = 1'b1; pin_raw[6] = 1'b1;
        serve(1'b1, got);
        chk(got && cap_pin == 2 && cap_lt, "R10", "lower pin first, level trig",
            {got, 3'(cap_pin)}, {1'b1, 3'd2});
        serve(1'b1, got);
        chk(got && cap_pin == 6 && cap_dlv == 3'b101, "R9", "second pin with delivery mode",
            {got, 3'(cap_pin)}, {1'b1, 3'd6});
        quiet(8, "R5", "in-service blocks repeat");
        eoi(8'h11, 8'h00, "R7");
        quiet(4, "R6", "unmatched EOI releases nothing");
        eoi(8'h52, 8'b0100_0100, "R7");
        serve(1'b1, got);
        chk(got && cap_pin == 2, "R6", "EOI refires pin 2", 3'(cap_pin), 2);
        serve(1'b1, got);
        chk(got && cap_pin == 6, "R6", "EOI refires pin 6", 3'(cap_pin), 6);
        pin_raw[2] = 1'b0;
        eoi(8'h52, 8'b0100_0100, "R7");
        serve(1'b1, got);
        chk(got && cap_pin == 6, "R6", "only still-high pin refires", 3'(cap_pin), 6);
        quiet(5, "R6", "dropped pin not refired");
    endtask

    task automatic t_level_reject();
        bit got;
        reset_dut();
        cfg_level_mode[7] = 1'b1; cfg_mask[7] = 1'b0;
        pin_raw[7] = 1'b1;
        serve(1'b0, got);
        chk(got && cap_pin == 7, "R3", "level offered", got, 1);
        serve(1'b1, got);
        chk(got && cap_pin == 7, "R3", "rejected level retried", got, 1);
        quiet(5, "R5", "accepted level blocked");
    endtask

    task automatic t_edge_reject();
        bit got;
        reset_dut();
        cfg_mask[1] = 1'b0;
        pin_raw[1] = 1'b1;
        serve(1'b0, got);
        chk(got && cap_pin == 1, "R11", "edge offered", got, 1);
        quiet(8, "R11", "rejected edge not retried");
    endtask

    task automatic t_pin0();
        bit got;
        reset_dut();
        cfg_mask[0] = 1'b0; cfg_mask[3] = 1'b0;
        cfg_vector[0 +: VW] = 8'h40; cfg_dest[0 +: DW] = 8'h5A; cfg_dest_logical[0] = 1'b1;
        cfg_dlv_mode[0 +: 3] = 3'b001;
        cfg_dest[3*DW +: DW] = 8'h5A; cfg_dest_logical[3] = 1'b1;
        pin_raw[0] = 1'b1; pin_raw[3] = 1'b1;
        serve(1'b1, got);
        chk(got && cap_pin == 0 && cap_dest == 8'h00 && !cap_log, "R8", "pin 0 forced physical 0",
            {cap_log, cap_dest}, 0);
        chk(cap_as && cap_sh == 2'b00 && cap_dlv == 3'b001 && cap_vec == 8'h40, "R9",
            "assert level, no shorthand", {cap_as, cap_sh}, 3'b100);
        serve(1'b1, got);
        chk(got && cap_pin == 3 && cap_dest == 8'h5A && cap_log, "R8", "pin 3 passes through",
            {cap_log, cap_dest}, {1'b1, 8'h5A});
    endtask

    task automatic t_hold();
        bit got;
        bit ok = 1'b1;
        reset_dut();
        cfg_mask[3] = 1'b0; cfg_vector[3*VW +: VW] = 8'h77;
        pin_raw[3] = 1'b1;
        for (int k = 0; k < 6 && !msg_valid; k++) @(negedge clk);
        cfg_vector[3*VW +: VW] = 8'h99;
        repeat (3) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h77 || msg_pin != 3) ok = 1'b0;
        end
        chk(ok, "R11", "message held stable", msg_vector, 8'h77);
        serve(1'b1, got);
        chk(got && cap_vec == 8'h77, "R11", "held message released", cap_vec, 8'h77);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_edge();
        t_polarity();
        t_mask();
        t_level_eoi();
        t_level_reject();
        t_edge_reject();
        t_pin0();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule